// File: doc/BRIEF.md
# Programming-Mode Entry Gate

This unit sits behind the instruction register of a boundary-scan test port. It holds two data registers that control entry into device programming: a one-bit register that keeps the processor core in reset, and a sixteen-bit key register. Each register is reached through its own serial shadow shifter, which captures, shifts least-significant bit first and updates under the usual data-register controls of the test port. An update is the only thing that changes the state behind a register.

Programming mode is granted only after two updates in this order. First, a 1 is placed in the core-reset register. Second, the exact 16-bit key is placed in the key register. To leave, zeros are written to the key register and then a 0 is written to the core-reset register. Releasing the core while the key is still loaded also ends programming mode, so the flag cannot outlive the reset. The test port's state machine, the programming command decoder and the memory operations are all outside this unit.

Top module: `pm_enable_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `core_hold` to 0, `prog_active` to 0 and `tdo` to 0.
- R2: Instruction code 0xC selects the core-reset register and code 0x4 selects the key register. Every other code selects neither register, including 0x0, 0x1, 0xF and the reserved codes 0x8 to 0xB. With an unselected code, capture, shift and update have no effect on `core_hold` or `prog_active`, and `tdo` is 0.
- R3: On each clock edge with `shift_dr` high, the selected shifter moves one place toward bit 0 and takes `tdi` into its top bit. `tdo` always shows bit 0 of the selected shifter, so a value shifted in least-significant bit first comes out in the same order.
- R4: An edge with `update_dr` high and code 0xC loads bit 0 of the reset shifter into `core_hold`, which shows the new value right after that edge.
- R5: An edge with `capture_dr` high loads the reset shifter with the present `core_hold` and loads the key shifter with all zeros.
- R6: An update of the key register holding exactly 0xA370, while `core_hold` is 1, sets `prog_active` right after that edge.
- R7: An update of the key register while `core_hold` is 0 leaves `prog_active` at 0, even when the value is the key.
- R8: An update of the key register holding any value other than 0xA370 clears `prog_active`. This includes all zeros and a value that differs from the key in one bit.
- R9: An update that loads 0 into `core_hold` clears `prog_active` at the same edge. `prog_active` is never 1 while `core_hold` is 0.
- R10: A test-logic reset pulse (`tap_reset`) clears `prog_active` after its edge and leaves `core_hold` unchanged.
- R11: Capture and shift without a following update leave `core_hold` and `prog_active` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_reset | input | 1 | Test-logic reset pulse from the port controller |
| ir_code | input | 4 | Current instruction code |
| capture_dr | input | 1 | Capture-DR state active |
| shift_dr | input | 1 | Shift-DR state active |
| update_dr | input | 1 | Update-DR state active |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out of the selected shifter |
| core_hold | output | 1 | Holds the processor core in reset |
| prog_active | output | 1 | Programming mode granted |

## Verification
Any fault in the gate state is visible at the two outputs right after the update edge that caused it. A wrong key compare or a missing ordering check shows up as `prog_active` being set, or not set, on the cycle after the update. A wrong decode lets a foreign instruction change `core_hold` after its update, or drive `tdo` during its shift. Shifter faults show up on `tdo` within one shift of the faulty bit, and they show up again at the next update.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int IR_W  = 4;
    localparam int KEY_W = 16;
    localparam int HLD_W = 1;

    localparam logic [IR_W-1:0]  IR_HOLD = 4'hC;
    localparam logic [IR_W-1:0]  IR_KEY  = 4'h4;
    localparam logic [KEY_W-1:0] KEY_VAL = 16'hA370;

    typedef enum logic [1:0] {
        DR_NONE = 2'd0,
        DR_HOLD = 2'd1,
        DR_KEY  = 2'd2
    } dr_sel_e;

    function automatic dr_sel_e decode_ir(input logic [IR_W-1:0] code);
        if (code == IR_HOLD) return DR_HOLD;
        if (code == IR_KEY)  return DR_KEY;
        return DR_NONE;
    endfunction

    function automatic logic is_key(input logic [KEY_W-1:0] v);
        return v == KEY_VAL;
    endfunction
endpackage

// File: rtl/pm_ir_decode.sv
module pm_ir_decode
    import pm_pkg::*;
(
    input  logic [IR_W-1:0] ir_code,
    output dr_sel_e         sel
);
    always_comb sel = decode_ir(ir_code);
endmodule

// File: rtl/pm_shadow.sv
module pm_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  logic         capture,
    input  logic         shift,
    input  logic         tdi,
    input  logic [W-1:0] cap_val,
    output logic [W-1:0] sr
);
    logic [W-1:0] nxt;

    generate
        if (W == 1) begin : g_one
            always_comb nxt = tdi;
        end else begin : g_wide
            always_comb nxt = {tdi, sr[W-1:1]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                  sr <= '0;
        else if (sel && capture)  sr <= cap_val;
        else if (sel && shift)    sr <= nxt;
    end

    // R11
    shadow_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel || (!capture && !shift)) |=> $stable(sr));
endmodule

// File: rtl/pm_mode_ctl.sv
module pm_mode_ctl (
    input  logic clk,
    input  logic rst,
    input  logic tap_reset,
    input  logic upd_hold,
    input  logic upd_key,
    input  logic hold_bit,
    input  logic key_ok,
    output logic core_hold,
    output logic prog_active
);
    logic hold_d, prog_d;

    always_comb begin
        hold_d = upd_hold ? hold_bit : core_hold;
        if (tap_reset)               prog_d = 1'b0;
        else if (upd_key)            prog_d = core_hold & key_ok;
        else if (upd_hold)           prog_d = prog_active & hold_bit;
        else                         prog_d = prog_active & core_hold;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_hold   <= 1'b0;
            prog_active <= 1'b0;
        end else begin
            core_hold   <= hold_d;
            prog_active <= prog_d;
        end
    end

    // R9
    prog_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        prog_active |-> core_hold);
    // R10
    tap_clear_chk: assert property (@(posedge clk) disable iff (rst)
        tap_reset |=> !prog_active);
    // R6
    prog_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_active) |-> $past(upd_key && key_ok));
    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_hold |=> $stable(core_hold));
endmodule

// File: rtl/pm_enable_unit.sv
module pm_enable_unit
    import pm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tap_reset,
    input  logic [IR_W-1:0] ir_code,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            tdi,
    output logic            tdo,
    output logic            core_hold,
    output logic            prog_active
);
    dr_sel_e          sel;
    logic [HLD_W-1:0] hold_sr;
    logic [KEY_W-1:0] key_sr;
    logic             sel_hold, sel_key;

    pm_ir_decode u_dec (.ir_code(ir_code), .sel(sel));

    assign sel_hold = (sel == DR_HOLD);
    assign sel_key  = (sel == DR_KEY);

    pm_shadow #(.W(HLD_W)) u_hold_sr (
        .clk(clk), .rst(rst), .sel(sel_hold), .capture(capture_dr),
        .shift(shift_dr), .tdi(tdi), .cap_val(core_hold), .sr(hold_sr)
    );

    pm_shadow #(.W(KEY_W)) u_key_sr (
        .clk(clk), .rst(rst), .sel(sel_key), .capture(capture_dr),
        .shift(shift_dr), .tdi(tdi), .cap_val('0), .sr(key_sr)
    );

    pm_mode_ctl u_ctl (
        .clk(clk), .rst(rst), .tap_reset(tap_reset),
        .upd_hold(update_dr && sel_hold), .upd_key(update_dr && sel_key),
        .hold_bit(hold_sr[0]), .key_ok(is_key(key_sr)),
        .core_hold(core_hold), .prog_active(prog_active)
    );

    always_comb begin
        unique case (sel)
            DR_HOLD: tdo = hold_sr[0];
            DR_KEY:  tdo = key_sr[0];
            default: tdo = 1'b0;
        endcase
    end

    // R2
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == DR_NONE) |-> !tdo);
endmodule

// File: tb/pm_enable_unit_test.sv
module pm_enable_unit_test;
    logic       clk = 1'b0;
    logic       rst, tap_reset, capture_dr, shift_dr, update_dr, tdi;
    logic [3:0] ir_code;
    logic       tdo, core_hold, prog_active;
    int         n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    pm_enable_unit uut (
        .clk(clk), .rst(rst), .tap_reset(tap_reset), .ir_code(ir_code),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .core_hold(core_hold), .prog_active(prog_active)
    );

    // {ir, value, expected core_hold, expected prog_active}
    localparam int NV = 15;
    localparam logic [21:0] VEC [NV] = '{
        {4'hC, 16'h0001, 1'b1, 1'b0},   // R4 set hold
        {4'h4, 16'hA370, 1'b1, 1'b1},   // R6 enter
        {4'h4, 16'h0000, 1'b1, 1'b0},   // R8 zeros leave
        {4'h4, 16'hA370, 1'b1, 1'b1},   // R6
        {4'h4, 16'hA371, 1'b1, 1'b0},   // R8 one-bit miss
        {4'h4, 16'hA370, 1'b1, 1'b1},   // R6
        {4'hC, 16'h0000, 1'b0, 1'b0},   // R9 release clears
        {4'h4, 16'hA370, 1'b0, 1'b0},   // R7 wrong order
        {4'h8, 16'hFFFF, 1'b0, 1'b0},   // R2 reserved
        {4'hC, 16'h0001, 1'b1, 1'b0},   // R4
        {4'hB, 16'hA370, 1'b1, 1'b0},   // R2 reserved
        {4'h0, 16'h0000, 1'b1, 1'b0},   // R2 other code
        {4'hF, 16'h0000, 1'b1, 1'b0},   // R2 other code
        {4'h4, 16'hA370, 1'b1, 1'b1},   // R6
        {4'h1, 16'h0000, 1'b1, 1'b1}    // R2 other code
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic dr_cycle(input logic [3:0] ir, input logic [15:0] v, input bit upd);
        int nb;
        nb = (ir == 4'hC) ? 1 : 16;
        @(negedge clk);
        ir_code = ir; capture_dr = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < nb; i++) begin
            tdi = v[i];
            if (ir != 4'hC && ir != 4'h4) chk("R2 tdo", {15'd0, tdo}, 16'd0);
            @(negedge clk);
        end
        shift_dr = 1'b0;
        if (upd) begin
            update_dr = 1'b1;
            @(negedge clk);
            update_dr = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; tap_reset = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0;
        update_dr = 1'b0; tdi = 1'b0; ir_code = 4'hC;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 hold", {15'd0, core_hold}, 16'd0);
        chk("R1 prog", {15'd0, prog_active}, 16'd0);
        chk("R1 tdo", {15'd0, tdo}, 16'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            dr_cycle(VEC[k][21:18], VEC[k][17:2], 1'b1);
            chk($sformatf("R4/R6-R9 hold vec%0d", k), {15'd0, core_hold}, {15'd0, VEC[k][1]});
            chk($sformatf("R2/R6-R9 prog vec%0d", k), {15'd0, prog_active}, {15'd0, VEC[k][0]});
        end

        // R5: reset shifter captures core_hold (1)
        @(negedge clk); ir_code = 4'hC; capture_dr = 1'b1;
        @(negedge clk); capture_dr = 1'b0;
        chk("R5 hold capture", {15'd0, tdo}, 16'd1);

        // R5/R3: key shifter captures zeros, ones appear only after 16 shifts
        @(negedge clk); ir_code = 4'h4; capture_dr = 1'b1;
        @(negedge clk); capture_dr = 1'b0; shift_dr = 1'b1; tdi = 1'b1;
        begin
            logic [15:0] seen;
            for (int i = 0; i < 16; i++) begin
                seen[i] = tdo;
                @(negedge clk);
            end
            chk("R5 key capture zeros", seen, 16'h0000);
            chk("R3 first shifted bit out", {15'd0, tdo}, 16'd1);
            // R3: shift a pattern in, then out again LSB first
            for (int i = 0; i < 16; i++) begin
                tdi = 16'h5A3C >> i;
                @(negedge clk);
            end
            tdi = 1'b0;
            for (int i = 0; i < 16; i++) begin
                seen[i] = tdo;
                @(negedge clk);
            end
            chk("R3 order", seen, 16'h5A3C);
        end
        shift_dr = 1'b0;
        // R11: no update, state untouched
        chk("R11 hold", {15'd0, core_hold}, 16'd1);
        chk("R11 prog", {15'd0, prog_active}, 16'd1);

        // R10: test-logic reset
        tap_reset = 1'b1;
        @(negedge clk); tap_reset = 1'b0;
        chk("R10 prog", {15'd0, prog_active}, 16'd0);
        chk("R10 hold", {15'd0, core_hold}, 16'd1);

        // R6 again, then R1 mid-run
        dr_cycle(4'h4, 16'hA370, 1'b1);
        chk("R6 re-entry", {15'd0, prog_active}, 16'd1);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 mid hold", {15'd0, core_hold}, 16'd0);
        chk("R1 mid prog", {15'd0, prog_active}, 16'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule